// File: doc/BRIEF.md
# Nonvolatile Write Completion Poller

This host-side controller waits for a nonvolatile memory to finish an internal program or erase operation. A pulse on `start` latches the target address, the expected byte, the kind of operation and a poll limit. The controller then reads that location over and over through a request/response read port and judges each returned byte as a status word.

Two status methods are available, chosen per operation. The complement method compares the top data bit with the top bit of the expected byte. The toggle method watches whether the second-highest bit stays the same between successive reads. The memory can finish while a read is in progress, so a single read that looks complete is not trusted. Completion is accepted only after that read is followed by two more reads that also look complete.

Once completion is confirmed, the controller waits a fixed settling interval. It then takes one last read and compares the whole byte. The outcome is a one-cycle `done` or `fail` pulse. A poll limit turns a memory that never finishes into a `fail`.

Top module: `nvp_done_poller`

## Requirements
- R1: A `start` pulse is accepted only while `busy` is low. It latches `tgt_addr`, `exp_data`, `mode_toggle`, `is_erase` and `max_polls`, and `busy` is high in the next cycle. A `start` pulse while `busy` is high has no effect on the reads issued or on the outcome.
- R2: `rd_req_valid` stays high with `rd_addr` unchanged until `rd_req_ready` is sampled high. Only one read is outstanding at a time. Every read goes to the address latched at start.
- R3: With `mode_toggle`=0, a status read looks complete when its bit 7 equals bit 7 of the latched expected byte for a program (`is_erase`=0), or equals 1 for an erase.
- R4: With `mode_toggle`=1, a status read looks complete when its bit 6 equals bit 6 of the previous status read of the same operation. The first status read of an operation never looks complete.
- R5: Completion is confirmed on the third consecutive status read that looks complete. Any status read that does not look complete restarts the count, and polling continues.
- R6: Each status response counts as one poll. If the poll numbered `max_polls` does not confirm completion, `fail` is raised and no further read is issued. A `max_polls` value of 0 acts as 1. A confirmation on the final allowed poll wins over the limit.
- R7: The request for the final full-byte read is raised exactly `SETTLE_CYC` clock cycles after the edge that consumed the confirming status response.
- R8: The final read's full byte is compared with the latched expected byte for a program, or with all ones for an erase. A match gives `done` and a mismatch gives `fail`.
- R9: `done` and `fail` are never high together. Each lasts one cycle, in the cycle after the deciding response, and exactly one of them fires per accepted start. `busy` falls in that same cycle.
- R10: While reset is held, and in the cycle after its release, `busy`, `done`, `fail` and `rd_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin polling; accepted only while idle |
| mode_toggle | input | 1 | 0 = complement-bit method, 1 = toggle-bit method |
| is_erase | input | 1 | 1 = erase (expected byte is all ones) |
| tgt_addr | input | ADDR_W | Location to poll |
| exp_data | input | DATA_W | Byte that was programmed |
| max_polls | input | POLL_W | Status-read limit (0 acts as 1) |
| busy | output | 1 | High from the cycle after an accepted start until the outcome pulse |
| done | output | 1 | One-cycle pulse: write completed and verified |
| fail | output | 1 | One-cycle pulse: poll limit reached or final byte wrong |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read address |
| rd_rsp_valid | input | 1 | Read response strobe |
| rd_rsp_data | input | DATA_W | Read response byte |

## Verification
The hardest case to reach is a lone status read that looks complete while the memory is still busy. Such a read must be absorbed by the confirmation step, not accepted. A close second is a confirmation that lands on exactly the last allowed poll. The bench builds, for each operation, a byte sequence that the memory will return. In it, busy patterns can carry a single injected "complete-looking" byte at a chosen position, and the busy length can be set relative to the poll limit. A bench function walks the same sequence under the requirement rules to predict the outcome, the read count and the settle gap. Request-ready stalls and response latency are randomised, so the handshake is stressed at the same time.

// File: rtl/nvp_pkg.sv
// Package: shared types for the write-completion poller.
// Assumes: nothing beyond SystemVerilog 2017 enum support.
package nvp_pkg;

    // Controller phases: status polling, settling, final full-byte read.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SREQ   = 3'd1,
        ST_SWAIT  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_VREQ   = 3'd4,
        ST_VWAIT  = 3'd5
    } nvp_state_e;

    // Status method selection.
    typedef enum logic {
        MODE_COMPLEMENT = 1'b0,
        MODE_TOGGLE     = 1'b1
    } nvp_mode_e;

endpackage

// File: rtl/nvp_status_eval.sv
// Module: nvp_status_eval
// Judges one returned byte. looks_done says whether the status read looks
// complete under the selected method. byte_match says whether the whole byte
// equals the expected final value.
// Assumes: prev_bit/have_prev hold the toggle bit of the previous status read
// of the same operation; purely combinational.
module nvp_status_eval
    import nvp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int POLL_BIT   = DATA_W - 1,
    parameter int TOGGLE_BIT = DATA_W - 2
) (
    input  nvp_mode_e          mode,
    input  logic               erase,
    input  logic [DATA_W-1:0]  exp_data,
    input  logic [DATA_W-1:0]  rsp_data,
    input  logic               prev_bit,
    input  logic               have_prev,
    output logic               looks_done,
    output logic               byte_match
);

    logic [DATA_W-1:0] final_byte;
    logic              want_poll_bit;

    // Expected final byte: all ones after an erase, else the programmed byte.
    always_comb begin
        final_byte    = erase ? {DATA_W{1'b1}} : exp_data;
        want_poll_bit = final_byte[POLL_BIT];
    end

    // Status decision for the selected method.
    always_comb begin
        if (mode == MODE_TOGGLE) begin
            looks_done = have_prev && (rsp_data[TOGGLE_BIT] == prev_bit);
        end else begin
            looks_done = (rsp_data[POLL_BIT] == want_poll_bit);
        end
    end

    // Full-byte comparison used on the final read.
    always_comb begin
        byte_match = (rsp_data == final_byte);
    end

endmodule

// File: rtl/nvp_poll_tracker.sv
// Module: nvp_poll_tracker
// Counts status polls and the run of consecutive complete-looking reads.
// confirm_now fires on the read that completes the confirmation run.
// exhaust_now fires on the poll that reaches the limit without confirming.
// Assumes: step is high for exactly one cycle per status response; clear is
// high on the cycle a new operation is accepted.
module nvp_poll_tracker #(
    parameter int POLL_W     = 16,
    parameter int STREAK_TGT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              ok,
    input  logic [POLL_W-1:0] max_polls,
    output logic              confirm_now,
    output logic              exhaust_now
);

    localparam int STREAK_W = $clog2(STREAK_TGT + 1);
    localparam logic [STREAK_W-1:0] STREAK_LAST = STREAK_W'(STREAK_TGT - 1);

    logic [STREAK_W-1:0] streak_q;
    logic [POLL_W-1:0]   polls_q;
    logic [POLL_W:0]     polls_next;
    logic [POLL_W:0]     limit;

    // Effective limit (zero acts as one) and the poll number after this step.
    always_comb begin
        limit      = (max_polls == '0) ? (POLL_W + 1)'(1) : {1'b0, max_polls};
        polls_next = {1'b0, polls_q} + (POLL_W + 1)'(1);
    end

    // Decisions taken on the current status response.
    always_comb begin
        confirm_now = step && ok && (streak_q == STREAK_LAST);
        exhaust_now = step && !confirm_now && (polls_next >= limit);
    end

    // Run-length and poll counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            streak_q <= '0;
            polls_q  <= '0;
        end else if (step) begin
            polls_q  <= polls_next[POLL_W-1:0];
            streak_q <= ok ? streak_q + STREAK_W'(1) : '0;
        end
    end

endmodule

// File: rtl/nvp_settle_timer.sv
// Module: nvp_settle_timer
// Counts the cycles spent in the settle phase. expired goes high in the
// cycle of the SETTLE_CYC-th consecutive cycle with run high.
// Assumes: SETTLE_CYC >= 1; run drops as soon as expired is seen.
module nvp_settle_timer #(
    parameter int SETTLE_CYC = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Terminal count reached while running.
    always_comb begin
        expired = run && (cnt_q == CNT_LAST);
    end

    // Counter that rests at zero whenever the settle phase is not active.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || expired) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/nvp_done_poller.sv
// Module: nvp_done_poller (top)
// Polls a nonvolatile memory location until its internal write finishes.
// Status reads are confirmed over a run of reads. After a settle interval,
// one last read checks the full byte. The result is a done or fail pulse.
// Assumes: the read port returns exactly one rd_rsp_valid strobe per accepted
// request, no earlier than the cycle after acceptance.
module nvp_done_poller
    import nvp_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int POLL_W        = 16,
    parameter int SETTLE_CYC    = 33,
    parameter int CONFIRM_READS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode_toggle,
    input  logic              is_erase,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DATA_W-1:0] exp_data,
    input  logic [POLL_W-1:0] max_polls,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data
);

    localparam int STREAK_TGT = CONFIRM_READS + 1;
    localparam int TOGGLE_BIT = DATA_W - 2;

    nvp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] exp_q;
    logic [POLL_W-1:0] maxp_q;
    nvp_mode_e         mode_q;
    logic              erase_q;
    logic              prev_bit_q;
    logic              have_prev_q;
    logic              done_q;
    logic              fail_q;

    logic start_acc;
    logic status_step;
    logic verify_step;
    logic looks_done;
    logic byte_match;
    logic confirm_now;
    logic exhaust_now;
    logic settle_run;
    logic settle_exp;

    // Strobes derived from the current phase.
    always_comb begin
        start_acc   = start && (state_q == ST_IDLE);
        status_step = (state_q == ST_SWAIT) && rd_rsp_valid;
        verify_step = (state_q == ST_VWAIT) && rd_rsp_valid;
        settle_run  = (state_q == ST_SETTLE);
    end

    nvp_status_eval #(
        .DATA_W     (DATA_W),
        .POLL_BIT   (DATA_W - 1),
        .TOGGLE_BIT (TOGGLE_BIT)
    ) u_eval (
        .mode       (mode_q),
        .erase      (erase_q),
        .exp_data   (exp_q),
        .rsp_data   (rd_rsp_data),
        .prev_bit   (prev_bit_q),
        .have_prev  (have_prev_q),
        .looks_done (looks_done),
        .byte_match (byte_match)
    );

    nvp_poll_tracker #(
        .POLL_W     (POLL_W),
        .STREAK_TGT (STREAK_TGT)
    ) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (start_acc),
        .step        (status_step),
        .ok          (looks_done),
        .max_polls   (maxp_q),
        .confirm_now (confirm_now),
        .exhaust_now (exhaust_now)
    );

    nvp_settle_timer #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (settle_run),
        .expired (settle_exp)
    );

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_acc)    state_d = ST_SREQ;
            ST_SREQ:   if (rd_req_ready) state_d = ST_SWAIT;
            ST_SWAIT: begin
                if (rd_rsp_valid) begin
                    if (confirm_now)      state_d = ST_SETTLE;
                    else if (exhaust_now) state_d = ST_IDLE;
                    else                  state_d = ST_SREQ;
                end
            end
            ST_SETTLE: if (settle_exp)   state_d = ST_VREQ;
            ST_VREQ:   if (rd_req_ready) state_d = ST_VWAIT;
            ST_VWAIT:  if (rd_rsp_valid) state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operation parameters captured at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            exp_q   <= '0;
            maxp_q  <= '0;
            mode_q  <= MODE_COMPLEMENT;
            erase_q <= 1'b0;
        end else if (start_acc) begin
            addr_q  <= tgt_addr;
            exp_q   <= exp_data;
            maxp_q  <= max_polls;
            mode_q  <= nvp_mode_e'(mode_toggle);
            erase_q <= is_erase;
        end
    end

    // Toggle-bit history of the previous status read.
    always_ff @(posedge clk) begin
        if (!rst_n || start_acc) begin
            prev_bit_q  <= 1'b0;
            have_prev_q <= 1'b0;
        end else if (status_step) begin
            prev_bit_q  <= rd_rsp_data[TOGGLE_BIT];
            have_prev_q <= 1'b1;
        end
    end

    // One-cycle outcome pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= verify_step && byte_match;
            fail_q <= (verify_step && !byte_match) || exhaust_now;
        end
    end

    // Output drive.
    always_comb begin
        busy         = (state_q != ST_IDLE);
        done         = done_q;
        fail         = fail_q;
        rd_req_valid = (state_q == ST_SREQ) || (state_q == ST_VREQ);
        rd_addr      = addr_q;
    end

endmodule

// File: rtl/nvp_done_poller_chk.sv
// Module: nvp_done_poller_chk
// Port-level protocol checks for nvp_done_poller, attached with bind.
// Assumes: the read port returns one response per accepted request.
module nvp_done_poller_chk #(
    parameter int ADDR_W = 19,
    parameter int POLL_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic [POLL_W-1:0] max_polls,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic              rd_req_valid,
    input logic              rd_req_ready,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_rsp_valid
);

    logic [ADDR_W-1:0] cap_addr;
    logic [POLL_W-1:0] cap_maxp;
    logic [POLL_W+1:0] rsp_cnt;
    logic              outstanding;

    // Shadow of the operation's address and limit, taken at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_maxp <= '0;
        end else if (start && !busy) begin
            cap_addr <= tgt_addr;
            cap_maxp <= max_polls;
        end
    end

    // Responses seen in the current operation.
    always_ff @(posedge clk) begin
        if (!rst_n || (start && !busy)) rsp_cnt <= '0;
        else if (rd_rsp_valid && busy)  rsp_cnt <= rsp_cnt + 1'b1;
    end

    // Outstanding-read flag from the handshake and the response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                            outstanding <= 1'b0;
        else if (rd_req_valid && rd_req_ready) outstanding <= 1'b1;
        else if (rd_rsp_valid)                 outstanding <= 1'b0;
    end

    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

    a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !rd_req_valid);

    a_r2_addr_latched: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (rd_addr == cap_addr));

    a_r6_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rsp_cnt <= ({2'b00, cap_maxp} + 2'd2)));

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_fail_single: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    a_r9_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || fail));

    a_r9_pulse_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fail) |-> (!busy && $past(busy)));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req_valid);

endmodule

bind nvp_done_poller nvp_done_poller_chk #(
    .ADDR_W (ADDR_W),
    .POLL_W (POLL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .tgt_addr     (tgt_addr),
    .max_polls    (max_polls),
    .busy         (busy),
    .done         (done),
    .fail         (fail),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_addr      (rd_addr),
    .rd_rsp_valid (rd_rsp_valid)
);

// File: tb/nvp_done_poller_test.sv
module nvp_done_poller_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 19;
    localparam int DATA_W     = 8;
    localparam int POLL_W     = 8;
    localparam int SETTLE     = 6;
    localparam int SEQ_N      = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              mode_toggle = 1'b0;
    logic              is_erase = 1'b0;
    logic [ADDR_W-1:0] tgt_addr = '0;
    logic [DATA_W-1:0] exp_data = '0;
    logic [POLL_W-1:0] max_polls = '0;
    logic              busy, done, fail;
    logic              rd_req_valid;
    logic              rd_req_ready = 1'b0;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_rsp_valid = 1'b0;
    logic [DATA_W-1:0] rd_rsp_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Memory model state.
    logic [7:0]        seq [SEQ_N];
    logic [7:0]        final_b;
    logic [ADDR_W-1:0] op_addr;
    int rd_idx = 0;
    int addr_err = 0;
    int first_vis [128];
    int rsp_cyc [128];
    bit seen_vis = 0;
    bit pend = 0;
    int lat = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nvp_done_poller #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .POLL_W     (POLL_W),
        .SETTLE_CYC (SETTLE)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .mode_toggle  (mode_toggle),
        .is_erase     (is_erase),
        .tgt_addr     (tgt_addr),
        .exp_data     (exp_data),
        .max_polls    (max_polls),
        .busy         (busy),
        .done         (done),
        .fail         (fail),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_addr      (rd_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data)
    );

    function automatic logic [7:0] get_b(int i);
        return (i < SEQ_N) ? seq[i] : final_b;
    endfunction

    task automatic chk(input bit cond, input string req, input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Walk the response sequence under the status rules (R3, R4, R5, R6).
    task automatic predict(input bit tog, input bit er, input logic [7:0] e,
                           input int maxp, output bit ok, output int n);
        int streak = 0;
        int limit = (maxp < 1) ? 1 : maxp;
        ok = 0;
        n = 0;
        for (int i = 0; i < 300; i++) begin
            logic [7:0] b = get_b(i);
            bit good;
            if (tog) good = (i > 0) && (b[6] == get_b(i - 1)[6]);
            else     good = (b[7] == (er ? 1'b1 : e[7]));
            streak = good ? streak + 1 : 0;
            if (streak == 3) begin ok = 1; n = i + 1; return; end
            if (i + 1 >= limit) begin ok = 0; n = i + 1; return; end
        end
    endtask

    // Read-port responder: random ready stalls and response latency.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            rd_rsp_valid = 1'b0;
            rd_req_ready = 1'b0;
            if (pend) begin
                if (lat == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data  = get_b(rd_idx);
                    if (rd_idx < 128) rsp_cyc[rd_idx] = cyc;
                    rd_idx++;
                    pend = 0;
                    seen_vis = 0;
                end else begin
                    lat--;
                end
            end else if (rd_req_valid) begin
                if (!seen_vis && rd_idx < 128) begin
                    first_vis[rd_idx] = cyc;
                    seen_vis = 1;
                end
                if (rd_addr != op_addr) addr_err++;
                if (($urandom % 3) != 0) begin
                    rd_req_ready = 1'b1;
                    pend = 1;
                    lat = $urandom % 3;
                end
            end
        end
    end

    // Build a status sequence: nbusy busy reads, optional glitch, then final.
    task automatic build(input bit tog, input bit er, input logic [7:0] e,
                         input int nbusy, input int glitch, input logic [7:0] fin);
        logic [7:0] want = er ? 8'hFF : e;
        final_b = fin;
        for (int i = 0; i < SEQ_N; i++) begin
            logic [7:0] r = 8'($urandom);
            if (i < nbusy) begin
                if (tog) r[6] = i[0];
                else     r[7] = ~want[7];
                seq[i] = r;
            end else begin
                seq[i] = fin;
            end
        end
        if (glitch >= 1 && glitch < nbusy) begin
            if (tog) seq[glitch][6] = seq[glitch - 1][6];
            else     seq[glitch][7] = want[7];
        end
    endtask

    task automatic run_op(input string tag, input bit tog, input bit er,
                          input logic [7:0] e, input int maxp, input int nbusy,
                          input int glitch, input bit bad_final, input bit inject);
        bit ok;
        int n;
        int dcnt = 0;
        int fcnt = 0;
        int pulse_busy = 0;
        int wd = 0;
        bit fin_seen = 0;
        int exp_out;
        int got_out;
        logic [7:0] want = er ? 8'hFF : e;
        logic [7:0] fin = bad_final ? (want ^ 8'h01) : want;
        logic [ADDR_W-1:0] a = ADDR_W'($urandom);

        build(tog, er, e, nbusy, glitch, fin);
        predict(tog, er, e, maxp, ok, n);
        exp_out = (ok && (get_b(n) == want)) ? 1 : 2;

        @(negedge clk);
        rd_idx = 0;
        addr_err = 0;
        seen_vis = 0;
        op_addr = a;
        tgt_addr = a;
        exp_data = e;
        mode_toggle = tog;
        is_erase = er;
        max_polls = POLL_W'(maxp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R1 busy after start ", tag}, int'(busy), 1);
        while (!fin_seen && wd < 4000) begin
            if (inject && wd == 2) begin
                start = 1'b1;
                tgt_addr = ~a;
                max_polls = 8'd1;
            end else begin
                start = 1'b0;
            end
            if (done) dcnt++;
            if (fail) fcnt++;
            if ((done || fail) && busy) pulse_busy++;
            if (done || fail) fin_seen = 1;
            @(negedge clk);
            wd++;
        end
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            if (done) dcnt++;
            if (fail) fcnt++;
            @(negedge clk);
        end
        chk(fin_seen, {"R9 outcome seen (watchdog) ", tag}, int'(fin_seen), 1);
        got_out = (dcnt > 0) ? 1 : ((fcnt > 0) ? 2 : 0);
        chk(got_out == exp_out, {"R5/R6/R8 outcome ", tag}, got_out, exp_out);
        chk(dcnt + fcnt == 1, {"R9 single pulse ", tag}, dcnt + fcnt, 1);
        chk(pulse_busy == 0, {"R9 busy low at pulse ", tag}, pulse_busy, 0);
        chk(rd_idx == (ok ? n + 1 : n), {"R5 read count ", tag}, rd_idx, ok ? n + 1 : n);
        chk(addr_err == 0, {"R2 read address ", tag}, addr_err, 0);
        if (ok && n < 128) begin
            // Verify request is first seen SETTLE+1 negedges after the confirming response strobe (R7).
            chk(first_vis[n] - rsp_cyc[n - 1] == SETTLE + 1, {"R7 settle gap ", tag},
                first_vis[n] - rsp_cyc[n - 1], SETTLE + 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk(!busy && !done && !fail && !rd_req_valid, "R10 outputs in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !fail && !rd_req_valid, "R10 outputs after reset", int'(rd_req_valid), 0);

        run_op("R3 poll program",        0, 0, 8'h5A, 20, 3, -1, 0, 0);
        run_op("R3 poll program hi",     0, 0, 8'hC3, 20, 4, -1, 0, 0);
        run_op("R3 poll erase",          0, 1, 8'h00, 20, 5, -1, 0, 0);
        run_op("R5 poll glitch",         0, 0, 8'h11, 30, 8, 3, 0, 0);
        run_op("R4 toggle",              1, 0, 8'h9C, 30, 6, -1, 0, 0);
        run_op("R4 toggle glitch",       1, 1, 8'h00, 30, 9, 4, 0, 0);
        run_op("R6 timeout",             0, 0, 8'h77, 5, 30, -1, 0, 0);
        run_op("R6 zero limit",          0, 0, 8'h80, 0, 0, -1, 0, 0);
        run_op("R6 confirm on last poll", 0, 0, 8'h22, 3, 0, -1, 0, 0);
        run_op("R8 verify mismatch",     0, 0, 8'h3C, 20, 2, -1, 1, 0);
        run_op("R1 start while busy",    0, 0, 8'h66, 20, 6, -1, 0, 1);

        for (int t = 0; t < 40; t++) begin
            bit tog = 1'($urandom);
            bit er = ($urandom % 4) == 0;
            int nb = $urandom % 20;
            int mp = 1 + ($urandom % 40);
            int gl = (($urandom % 3) == 0) ? int'($urandom % 20) : -1;
            bit bad = ($urandom % 6) == 0;
            run_op("R5 random", tog, er, 8'($urandom), mp, nb, gl, bad, 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule